// File: doc/BRIEF.md
# Tiny External Read Buffer with Burst Memory Model

This block is a 128-byte direct-mapped read buffer. It sits between a processor's 32-bit memory port and a slower external memory. A request is taken when `cpu_req` and `cpu_ready` are both high at a clock edge. For a read, the registered address is compared with the stored tag for its line. On a hit, the word comes back on the next cycle. On a miss, the complete line is fetched from a behavioural burst memory inside the block, starting at word 0. The requested word is returned only once every word of the line is valid. A write goes straight through to memory, and it invalidates the buffered line if that line holds the written address.

The memory model has a 4-byte data path and two timing modes, chosen by `ddr_mode` at the moment a burst is requested. In single-rate mode the first word arrives 5 cycles after the request and one word follows on each later cycle. In double-rate mode the first word also arrives after 5 cycles, and two words are then delivered on each clock. The block also keeps a read-hit counter and a read-miss counter, which a power accumulator can sample.

The controller has four states. IDLE is the only state that accepts a request (IDLE→LOOKUP). LOOKUP compares the tag and acknowledges a write (LOOKUP→IDLE), answers a read hit (LOOKUP→IDLE), or starts a burst on a read miss (LOOKUP→FILL). FILL collects the memory beats and leaves on the beat that completes the line (FILL→REPLY). REPLY presents the word and returns to IDLE (REPLY→IDLE). The memory model has three states: IDLE, WAIT (counting the first-word delay) and XFER (delivering beats).

Top module: `tiny_line_buffer`

## Requirements
- R1: While reset is held, and on the first edge after it is released, `cpu_ready` is 1, `cpu_rvalid` is 0, both counters are 0, and every line is invalid, so the first read of any address is a miss.
- R2: A read that hits raises `cpu_rvalid` with the stored word in the first cycle after the accepting edge (latency 1).
- R3: In single-rate mode a read miss answers with latency 2 + 5 + W edges, where W is the number of words per line. With the default 16-byte line, W = 4 and the latency is 11. The memory delivers one word per cycle after a first-word delay of 5 cycles.
- R4: In double-rate mode a read miss answers with latency 2 + 5 + W/2 edges, which is 9 with the default line. Two words arrive per clock after the 5-cycle first-word delay.
- R5: A miss fills the entire line, word 0 first. Afterwards, every word of that line is a hit that returns the memory contents.
- R6: A write is acknowledged by `cpu_rvalid` one cycle after acceptance and updates memory. If the write address is resident, its line is invalidated, so the next read of that line misses and returns the new data.
- R7: A write to an address that is not resident leaves the resident line at the same index valid, and that line still hits.
- R8: `hit_count` increases by one for each read hit and `miss_count` by one for each read miss. Writes change neither counter.
- R9: `cpu_ready` is low from the accepting edge until the response cycle ends. Each request gets exactly one `cpu_rvalid` pulse.
- R10: Addresses are byte addresses and word aligned. The line index is word-address bits [4:2] (8 lines of 16 bytes) and the tag is the bits above them. Two addresses with the same index and different tags evict each other.
- R11: After reset, the memory word at word address n holds 0xC0DE0000 + n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ddr_mode | input | 1 | 1 selects double-rate burst timing, sampled when a burst starts |
| cpu_req | input | 1 | Request strobe |
| cpu_we | input | 1 | 1 for a write, 0 for a read |
| cpu_addr | input | ADDR_W (10) | Byte address, word aligned |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | Block can accept a request |
| cpu_rvalid | output | 1 | Response strobe (read data or write acknowledge) |
| cpu_rdata | output | 32 | Read data, valid with `cpu_rvalid` on reads |
| hit_count | output | CNT_W (16) | Read-hit counter |
| miss_count | output | CNT_W (16) | Read-miss counter |

## Verification
The assertions assume that every accepted address is word aligned and that `ddr_mode` holds steady while a burst is in progress. They also assume that no request arrives while `cpu_ready` is low. The bench drives only aligned addresses and raises `cpu_req` only in IDLE, for one cycle at a time. It changes `ddr_mode` only between transactions, so a whole fill always runs under one timing mode.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_FILL,
        ST_REPLY
    } ctrl_state_e;

    typedef enum logic [1:0] {
        MS_IDLE,
        MS_WAIT,
        MS_XFER
    } mem_state_e;

    localparam logic [31:0] MEM_SEED = 32'hC0DE_0000;

    function automatic logic [31:0] seed_word(input int unsigned n);
        return MEM_SEED + 32'(n);
    endfunction

endpackage

// File: rtl/tlb_burst_mem.sv
module tlb_burst_mem
    import tlb_pkg::*;
#(
    parameter int WADDR_W    = 8,
    parameter int FIRST_LAT  = 5,
    parameter int LINE_WORDS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ddr_mode_i,
    input  logic               wr_en_i,
    input  logic [WADDR_W-1:0] wr_addr_i,
    input  logic [31:0]        wr_data_i,
    input  logic               burst_req_i,
    input  logic [WADDR_W-1:0] burst_base_i,
    output logic               beat_valid_o,
    output logic               beat_two_o,
    output logic [31:0]        beat_lo_o,
    output logic [31:0]        beat_hi_o
);

    localparam int DEPTH  = 1 << WADDR_W;
    localparam int WAIT_W = $clog2(FIRST_LAT + 1);
    localparam int LEFT_W = $clog2(LINE_WORDS + 1);

    logic [31:0]        mem_q [DEPTH];
    mem_state_e         ms_q;
    logic [WAIT_W-1:0]  wait_q;
    logic [WADDR_W-1:0] ptr_q;
    logic [LEFT_W-1:0]  left_q;
    logic               ddr_q;
    logic [LEFT_W-1:0]  step;

    assign step = ddr_q ? LEFT_W'(2) : LEFT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= seed_word(i);
            end
        end else if (wr_en_i) begin
            mem_q[wr_addr_i] <= wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ms_q   <= MS_IDLE;
            wait_q <= '0;
            ptr_q  <= '0;
            left_q <= '0;
            ddr_q  <= 1'b0;
        end else begin
            unique case (ms_q)
                MS_IDLE: begin
                    if (burst_req_i) begin
                        ptr_q  <= burst_base_i;
                        left_q <= LEFT_W'(LINE_WORDS);
                        ddr_q  <= ddr_mode_i;
                        wait_q <= WAIT_W'(FIRST_LAT - 1);
                        ms_q   <= MS_WAIT;
                    end
                end
                MS_WAIT: begin
                    if (wait_q == '0) ms_q <= MS_XFER;
                    else              wait_q <= wait_q - 1'b1;
                end
                MS_XFER: begin
                    ptr_q  <= ptr_q + WADDR_W'(step);
                    left_q <= left_q - step;
                    if (left_q == step) ms_q <= MS_IDLE;
                end
                default: ms_q <= MS_IDLE;
            endcase
        end
    end

    always_comb begin
        beat_valid_o = (ms_q == MS_XFER);
        beat_two_o   = (ms_q == MS_XFER) && ddr_q;
        beat_lo_o    = mem_q[ptr_q];
        beat_hi_o    = mem_q[WADDR_W'(ptr_q + 1'b1)];
    end

    // cycles since the last accepted burst request, saturating
    logic [15:0] since_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              since_q <= 16'hFFFF;
        else if (ms_q == MS_IDLE && burst_req_i) since_q <= '0;
        else if (since_q != 16'hFFFF)            since_q <= since_q + 1'b1;
    end

    assert_first_word_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ms_q == MS_XFER && $past(ms_q) == MS_WAIT) |-> since_q == 16'(FIRST_LAT));

    assert_single_rate_back_to_back_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ms_q == MS_XFER && !ddr_q && left_q > 1) |=> ms_q == MS_XFER);

    assert_double_rate_pairs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ms_q == MS_XFER && ddr_q) |-> left_q >= LEFT_W'(2));

endmodule

// File: rtl/tlb_store.sv
module tlb_store #(
    parameter int LINES      = 8,
    parameter int LINE_WORDS = 4,
    parameter int IDX_W      = 3,
    parameter int OFF_W      = 2,
    parameter int TAG_W      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] look_idx_i,
    input  logic [OFF_W-1:0] look_off_i,
    input  logic [TAG_W-1:0] look_tag_i,
    output logic             hit_o,
    output logic [31:0]      rdata_o,
    input  logic             alloc_i,
    input  logic             fill_we_i,
    input  logic             fill_two_i,
    input  logic [OFF_W-1:0] fill_off_i,
    input  logic [31:0]      fill_lo_i,
    input  logic [31:0]      fill_hi_i,
    input  logic             fill_done_i,
    input  logic             inval_i
);

    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q  [LINES];
    logic [31:0]      data_q [LINES][LINE_WORDS];

    always_comb begin
        hit_o   = valid_q[look_idx_i] && (tag_q[look_idx_i] == look_tag_i);
        rdata_o = data_q[look_idx_i][look_off_i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            if (alloc_i)                valid_q[look_idx_i] <= 1'b0;
            else if (fill_done_i)       valid_q[look_idx_i] <= 1'b1;
            else if (inval_i && hit_o)  valid_q[look_idx_i] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (alloc_i) tag_q[look_idx_i] <= look_tag_i;
        if (fill_we_i) begin
            data_q[look_idx_i][fill_off_i] <= fill_lo_i;
            if (fill_two_i) data_q[look_idx_i][OFF_W'(fill_off_i + 1'b1)] <= fill_hi_i;
        end
    end

    assert_write_hit_drops_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (inval_i && hit_o) |=> !hit_o);

    assert_alloc_only_on_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |-> !hit_o);

endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
    import tlb_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int WADDR_W    = 8,
    parameter int LINE_WORDS = 4,
    parameter int OFF_W      = 2,
    parameter int IDX_W      = 3,
    parameter int TAG_W      = 3,
    parameter int CNT_W      = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_req_i,
    input  logic               cpu_we_i,
    input  logic [ADDR_W-1:0]  cpu_addr_i,
    input  logic [31:0]        cpu_wdata_i,
    output logic               cpu_ready_o,
    output logic               cpu_rvalid_o,
    output logic [31:0]        cpu_rdata_o,
    output logic [IDX_W-1:0]   look_idx_o,
    output logic [OFF_W-1:0]   look_off_o,
    output logic [TAG_W-1:0]   look_tag_o,
    input  logic               hit_i,
    input  logic [31:0]        line_data_i,
    output logic               alloc_o,
    output logic               fill_we_o,
    output logic               fill_two_o,
    output logic [OFF_W-1:0]   fill_off_o,
    output logic [31:0]        fill_lo_o,
    output logic [31:0]        fill_hi_o,
    output logic               fill_done_o,
    output logic               inval_o,
    output logic               mem_we_o,
    output logic [WADDR_W-1:0] mem_waddr_o,
    output logic [31:0]        mem_wdata_o,
    output logic               burst_req_o,
    output logic [WADDR_W-1:0] burst_base_o,
    input  logic               beat_valid_i,
    input  logic               beat_two_i,
    input  logic [31:0]        beat_lo_i,
    input  logic [31:0]        beat_hi_i,
    output logic [CNT_W-1:0]   hit_count_o,
    output logic [CNT_W-1:0]   miss_count_o
);

    localparam int GOT_W = $clog2(LINE_WORDS + 1);

    ctrl_state_e        st_q, st_d;
    logic [WADDR_W-1:0] waddr_q;
    logic               we_q;
    logic [31:0]        wdata_q;
    logic [GOT_W-1:0]   got_q;
    logic [CNT_W-1:0]   hit_cnt_q, miss_cnt_q;
    logic [GOT_W-1:0]   beat_n;
    logic               last_beat;

    assign beat_n    = beat_two_i ? GOT_W'(2) : GOT_W'(1);
    assign last_beat = beat_valid_i && ((got_q + beat_n) == GOT_W'(LINE_WORDS));

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (cpu_req_i) st_d = ST_LOOKUP;
            ST_LOOKUP: st_d = (we_q || hit_i) ? ST_IDLE : ST_FILL;
            ST_FILL:   if (last_beat) st_d = ST_REPLY;
            ST_REPLY:  st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            waddr_q    <= '0;
            we_q       <= 1'b0;
            wdata_q    <= '0;
            got_q      <= '0;
            hit_cnt_q  <= '0;
            miss_cnt_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && cpu_req_i) begin
                waddr_q <= cpu_addr_i[ADDR_W-1:2];
                we_q    <= cpu_we_i;
                wdata_q <= cpu_wdata_i;
            end
            if (st_q == ST_LOOKUP && !we_q) begin
                if (hit_i) hit_cnt_q  <= hit_cnt_q + 1'b1;
                else       miss_cnt_q <= miss_cnt_q + 1'b1;
                got_q <= '0;
            end
            if (st_q == ST_FILL && beat_valid_i) got_q <= got_q + beat_n;
        end
    end

    // outputs
    always_comb begin
        cpu_ready_o  = (st_q == ST_IDLE);
        cpu_rvalid_o = ((st_q == ST_LOOKUP) && (we_q || hit_i)) || (st_q == ST_REPLY);
        cpu_rdata_o  = line_data_i;
        look_off_o   = waddr_q[OFF_W-1:0];
        look_idx_o   = waddr_q[OFF_W +: IDX_W];
        look_tag_o   = waddr_q[WADDR_W-1 -: TAG_W];
        alloc_o      = (st_q == ST_LOOKUP) && !we_q && !hit_i;
        burst_req_o  = alloc_o;
        burst_base_o = {waddr_q[WADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        mem_we_o     = (st_q == ST_LOOKUP) && we_q;
        mem_waddr_o  = waddr_q;
        mem_wdata_o  = wdata_q;
        inval_o      = mem_we_o;
        fill_we_o    = (st_q == ST_FILL) && beat_valid_i;
        fill_two_o   = beat_two_i;
        fill_off_o   = got_q[OFF_W-1:0];
        fill_lo_o    = beat_lo_i;
        fill_hi_o    = beat_hi_i;
        fill_done_o  = (st_q == ST_FILL) && last_beat;
        hit_count_o  = hit_cnt_q;
        miss_count_o = miss_cnt_q;
    end

    assert_aligned_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_i && cpu_ready_o) |-> cpu_addr_i[1:0] == 2'b00);

    assert_accept_drops_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_i && cpu_ready_o) |=> !cpu_ready_o);

    assert_rvalid_implies_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rvalid_o |-> !cpu_ready_o);

    assert_hit_next_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cpu_req_i && cpu_ready_o) && !we_q && hit_i) |-> cpu_rvalid_o);

    assert_reply_line_complete_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_REPLY) |-> hit_i);

    assert_hit_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_cnt_q != $past(hit_cnt_q)) |-> ($past(cpu_rvalid_o) && !$past(we_q)));

    assert_miss_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_cnt_q != $past(miss_cnt_q)) |-> (st_q == ST_FILL));

endmodule

// File: rtl/tiny_line_buffer.sv
module tiny_line_buffer #(
    parameter int ADDR_W     = 10,
    parameter int BUF_BYTES  = 128,
    parameter int LINE_BYTES = 16,
    parameter int FIRST_LAT  = 5,
    parameter int CNT_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ddr_mode,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [31:0]       cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_rvalid,
    output logic [31:0]       cpu_rdata,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);

    localparam int LINE_WORDS = LINE_BYTES / 4;
    localparam int LINES      = BUF_BYTES / LINE_BYTES;
    localparam int WADDR_W    = ADDR_W - 2;
    localparam int OFF_W      = $clog2(LINE_WORDS);
    localparam int IDX_W      = $clog2(LINES);
    localparam int TAG_W      = WADDR_W - OFF_W - IDX_W;

    logic [IDX_W-1:0]   look_idx;
    logic [OFF_W-1:0]   look_off;
    logic [TAG_W-1:0]   look_tag;
    logic               hit;
    logic [31:0]        line_data;
    logic               alloc, fill_we, fill_two, fill_done, inval;
    logic [OFF_W-1:0]   fill_off;
    logic [31:0]        fill_lo, fill_hi;
    logic               mem_we, burst_req;
    logic [WADDR_W-1:0] mem_waddr, burst_base;
    logic [31:0]        mem_wdata;
    logic               beat_valid, beat_two;
    logic [31:0]        beat_lo, beat_hi;

    tlb_ctrl #(
        .ADDR_W(ADDR_W), .WADDR_W(WADDR_W), .LINE_WORDS(LINE_WORDS),
        .OFF_W(OFF_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .CNT_W(CNT_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr),
        .cpu_wdata_i(cpu_wdata), .cpu_ready_o(cpu_ready),
        .cpu_rvalid_o(cpu_rvalid), .cpu_rdata_o(cpu_rdata),
        .look_idx_o(look_idx), .look_off_o(look_off), .look_tag_o(look_tag),
        .hit_i(hit), .line_data_i(line_data),
        .alloc_o(alloc), .fill_we_o(fill_we), .fill_two_o(fill_two),
        .fill_off_o(fill_off), .fill_lo_o(fill_lo), .fill_hi_o(fill_hi),
        .fill_done_o(fill_done), .inval_o(inval),
        .mem_we_o(mem_we), .mem_waddr_o(mem_waddr), .mem_wdata_o(mem_wdata),
        .burst_req_o(burst_req), .burst_base_o(burst_base),
        .beat_valid_i(beat_valid), .beat_two_i(beat_two),
        .beat_lo_i(beat_lo), .beat_hi_i(beat_hi),
        .hit_count_o(hit_count), .miss_count_o(miss_count)
    );

    tlb_store #(
        .LINES(LINES), .LINE_WORDS(LINE_WORDS),
        .IDX_W(IDX_W), .OFF_W(OFF_W), .TAG_W(TAG_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .look_idx_i(look_idx), .look_off_i(look_off), .look_tag_i(look_tag),
        .hit_o(hit), .rdata_o(line_data),
        .alloc_i(alloc), .fill_we_i(fill_we), .fill_two_i(fill_two),
        .fill_off_i(fill_off), .fill_lo_i(fill_lo), .fill_hi_i(fill_hi),
        .fill_done_i(fill_done), .inval_i(inval)
    );

    tlb_burst_mem #(
        .WADDR_W(WADDR_W), .FIRST_LAT(FIRST_LAT), .LINE_WORDS(LINE_WORDS)
    ) u_mem (
        .clk(clk), .rst_n(rst_n), .ddr_mode_i(ddr_mode),
        .wr_en_i(mem_we), .wr_addr_i(mem_waddr), .wr_data_i(mem_wdata),
        .burst_req_i(burst_req), .burst_base_i(burst_base),
        .beat_valid_o(beat_valid), .beat_two_o(beat_two),
        .beat_lo_o(beat_lo), .beat_hi_o(beat_hi)
    );

    assert_reset_state_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (cpu_ready && !cpu_rvalid && hit_count == '0 && miss_count == '0));

    assert_counters_monotonic_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_count != $past(miss_count)) |-> (miss_count == $past(miss_count) + 1'b1));

endmodule

// File: tb/tiny_line_buffer_tb.sv
module tiny_line_buffer_tb_top;

    localparam int FIRST_LAT = 5;
    localparam int W         = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ddr_mode = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [9:0]  cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_ready, cpu_rvalid;
    logic [31:0] cpu_rdata;
    logic [15:0] hit_count, miss_count;

    int vectors = 0;
    int fails   = 0;
    int exp_hits = 0;
    int exp_miss = 0;
    bit finished = 1'b0;

    logic [31:0] mword [256];
    logic        bval  [8];
    logic [2:0]  btag  [8];

    always #10 clk = ~clk;

    tiny_line_buffer dut_i (
        .clk(clk), .rst_n(rst_n), .ddr_mode(ddr_mode),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid),
        .cpu_rdata(cpu_rdata), .hit_count(hit_count), .miss_count(miss_count)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic read_op(input logic [9:0] addr, input string req);
        logic [7:0] w;
        bit         hit;
        int         exp_lat;
        int         n;
        w   = addr[9:2];
        hit = bval[w[4:2]] && (btag[w[4:2]] == w[7:5]);
        exp_lat = hit ? 1 : (ddr_mode ? 2 + FIRST_LAT + W/2 : 2 + FIRST_LAT + W);
        @(negedge clk);
        chk(req, "ready before request", 32'(cpu_ready), 32'd1);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = addr;
        @(posedge clk);
        @(negedge clk);
        cpu_req = 1'b0;
        n = 1;
        if (!hit) chk("R9", "ready during fill", 32'(cpu_ready), 32'd0);
        while (!cpu_rvalid && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk(req, "read latency", 32'(n), 32'(exp_lat));
        chk(req, "read data", cpu_rdata, mword[w]);
        @(negedge clk);
        chk("R9", "single response pulse", 32'(cpu_rvalid), 32'd0);
        if (hit) exp_hits++;
        else begin
            exp_miss++;
            bval[w[4:2]] = 1'b1;
            btag[w[4:2]] = w[7:5];
        end
        chk("R8", "hit counter", 32'(hit_count), 32'(exp_hits));
        chk("R8", "miss counter", 32'(miss_count), 32'(exp_miss));
    endtask

    task automatic write_op(input logic [9:0] addr, input logic [31:0] data, input string req);
        logic [7:0] w;
        w = addr[9:2];
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = addr; cpu_wdata = data;
        @(posedge clk);
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
        chk(req, "write ack next cycle", 32'(cpu_rvalid), 32'd1);
        mword[w] = data;
        if (bval[w[4:2]] && btag[w[4:2]] == w[7:5]) bval[w[4:2]] = 1'b0;
        @(negedge clk);
        chk("R8", "hit counter after write", 32'(hit_count), 32'(exp_hits));
        chk("R8", "miss counter after write", 32'(miss_count), 32'(exp_miss));
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "ready in reset", 32'(cpu_ready), 32'd1);
        chk("R1", "rvalid in reset", 32'(cpu_rvalid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "ready after reset", 32'(cpu_ready), 32'd1);
        chk("R1", "rvalid after reset", 32'(cpu_rvalid), 32'd0);
        chk("R1", "hit count reset", 32'(hit_count), 32'd0);
        chk("R1", "miss count reset", 32'(miss_count), 32'd0);
    endtask

    task automatic t_sdr_miss();
        ddr_mode = 1'b0;
        read_op(10'h014, "R3");
        chk("R11", "seeded word 5", cpu_rdata, 32'hC0DE_0005);
    endtask

    task automatic t_line_hits();
        read_op(10'h010, "R5");
        read_op(10'h018, "R5");
        read_op(10'h01C, "R2");
        read_op(10'h014, "R2");
    endtask

    task automatic t_ddr_miss();
        ddr_mode = 1'b1;
        read_op(10'h10C, "R4");
        read_op(10'h100, "R5");
        read_op(10'h104, "R5");
        ddr_mode = 1'b0;
    endtask

    task automatic t_conflict();
        read_op(10'h094, "R10");
        read_op(10'h014, "R10");
        read_op(10'h094, "R10");
    endtask

    task automatic t_write_hit();
        read_op(10'h018, "R10");
        write_op(10'h018, 32'h1234_5678, "R6");
        read_op(10'h018, "R6");
        chk("R6", "new data visible", cpu_rdata, 32'h1234_5678);
        read_op(10'h010, "R6");
    endtask

    task automatic t_write_elsewhere();
        write_op(10'h300, 32'hDEAD_BEEF, "R7");
        read_op(10'h108, "R7");
        read_op(10'h300, "R7");
        chk("R7", "passthrough data", cpu_rdata, 32'hDEAD_BEEF);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mword[i] = 32'hC0DE_0000 + 32'(i);
        for (int i = 0; i < 8; i++) begin
            bval[i] = 1'b0;
            btag[i] = '0;
        end
        repeat (3) @(posedge clk);
        t_reset();
        t_sdr_miss();
        t_line_hits();
        t_ddr_miss();
        t_conflict();
        t_write_hit();
        t_write_elsewhere();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            vectors++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule